// File: doc/BRIEF.md
# Tagged ADC Sample FIFO

This block buffers conversion results on their way from an ADC sequencer to a register-read interface. Each incoming result is 12 bits wide. It carries a 4-bit tag that names the sequencer step which produced it, not the analog input. The value and its tag are stored together as one 16-bit word. The read side has two ports. A data port pops one word on each read. A count port reports how many words are currently held.

The buffer never blocks the producer. A sample that arrives while all 64 entries are occupied, with no read in the same cycle, evicts the oldest entry and raises a sticky overrun flag. A per-step range check can also be enabled. It compares each incoming value with a programmed maximum and raises a sticky out-of-range flag when the value is larger. Both flags are cleared by writing a one to their clear input.

Top module: `tagged_adc_fifo`

## Requirements
- R1: A popped word carries the producing step tag in bits 15:12 and the 12-bit conversion value in bits 11:0.
- R2: Words leave in arrival order. While `rd_en` is high and the buffer is not empty, `rd_data` shows the oldest word. That word is removed at the clock edge, and `level` drops by one when no write occurs in the same cycle.
- R3: `level` never exceeds 64 and reads exactly 64 while the buffer is full.
- R4: A write into a full buffer with no read in the same cycle discards the oldest word and appends the new one. `level` stays at 64 and the following read returns the previously second-oldest word.
- R5: `ovr_flag` rises one cycle after a write into a full buffer that has no read in the same cycle, and it then stays high. A simultaneous read and write on a full buffer does not set it.
- R6: `oor_flag` rises one cycle after a write whose step bit in `chk_mask` is 1 and whose value is strictly greater than `chk_max`. A value equal to `chk_max` does not set it, and neither does a write from a step whose mask bit is 0.
- R7: A 1 on `ovr_clr` or `oor_clr` clears the matching flag at the next edge. If a setting event occurs in the same cycle as the clear, the flag stays set.
- R8: A read while the buffer is empty shows 0 on `rd_data` and leaves `level` at 0. A read and a write together on an empty buffer simply store the written word, so `level` becomes 1.
- R9: A read and a write in the same cycle on a non-empty buffer leave `level` unchanged, and `rd_data` shows the oldest word.
- R10: After reset `level` is 0, both flags are 0 and `rd_data` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Sample valid from the sequencer |
| wr_value | input | 12 | Conversion result |
| wr_step | input | 4 | Step that produced the result |
| rd_en | input | 1 | Destructive read of the data port |
| rd_data | output | 16 | Oldest word {tag, value}, or 0 when empty |
| level | output | 7 | Number of stored words |
| chk_max | input | 12 | Range check upper limit |
| chk_mask | input | 16 | Per-step enable for the range check |
| ovr_clr | input | 1 | Write-1 clear of the overrun flag |
| oor_clr | input | 1 | Write-1 clear of the out-of-range flag |
| ovr_flag | output | 1 | Sticky overrun flag |
| oor_flag | output | 1 | Sticky out-of-range flag |

## Verification
The interesting collision is a write and a read that land in the same cycle. The hardest case is a full buffer: a pop with an append must not be mistaken for an eviction, so the level must stay at 64 and no overrun may be reported. The bench issues combined reads and writes at levels 0, 1, mid-fill and 64, and checks `rd_data`, `level` and `ovr_flag` each cycle against a queue model. A second collision, a flag clear arriving in the same cycle as a new setting event, is provoked for both flags, and the flag is expected to stay set.

// File: rtl/adcbuf_pkg.sv
package adcbuf_pkg;
   localparam int TAG_W = 4;
   localparam int VAL_W = 12;
   localparam int WORD_W = TAG_W + VAL_W;
   typedef struct packed {
      logic [TAG_W-1:0] tag;
      logic [VAL_W-1:0] val;
   } word_t;
endpackage

// File: rtl/adcbuf_store.sv
module adcbuf_store #(
   parameter int DEPTH = 64,
   parameter int WIDTH = 16,
   localparam int AW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic             pop_req,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic [CW-1:0]    count,
   output logic             evict
);
   initial begin : elab_chk
      assert ((1 << AW) == DEPTH) else $error("DEPTH must be a power of two");
      assert (DEPTH >= 2) else $error("DEPTH too small");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr, rptr;
   logic             full, empty, do_pop, adv_r;

   assign full   = (count == CW'(DEPTH));
   assign empty  = (count == '0);
   assign do_pop = pop_req & ~empty;
   assign evict  = push & full & ~do_pop;
   assign adv_r  = do_pop | evict;
   assign dout   = empty ? '0 : mem[rptr];

   always_ff @(posedge clk) begin
      if (push) mem[wptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push)  wptr <= wptr + 1'b1;
         if (adv_r) rptr <= rptr + 1'b1;
         if (push && !do_pop && !full)  count <= count + 1'b1;
         else if (do_pop && !push)      count <= count - 1'b1;
      end
   end

   AST_LEVEL_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH)); // R3
   AST_FULL_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !pop_req && count == CW'(DEPTH)) |=> count == CW'(DEPTH)); // R4
   AST_RDWR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop_req && count != '0) |=> $stable(count)); // R9
   AST_EMPTY_RD: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_req && !push && count == '0) |=> count == '0); // R8
endmodule

// File: rtl/adcbuf_range.sv
module adcbuf_range #(
   parameter int  VAL_W  = 12,
   parameter int  TAG_W  = 4,
   parameter bit  ENABLE = 1'b1,
   localparam int STEPS  = 1 << TAG_W
) (
   input  logic             valid,
   input  logic [VAL_W-1:0] value,
   input  logic [TAG_W-1:0] step,
   input  logic [VAL_W-1:0] limit,
   input  logic [STEPS-1:0] mask,
   output logic             hit
);
   generate
      if (ENABLE) begin : g_chk
         assign hit = valid & mask[step] & (value > limit);
      end else begin : g_nochk
         logic unused;
         assign unused = ^{valid, value, step, limit, mask};
         assign hit    = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/adcbuf_flag.sv
module adcbuf_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic q
);
   always_ff @(posedge clk) begin
      if (!rst_n)    q <= 1'b0;
      else if (set)  q <= 1'b1;
      else if (clr)  q <= 1'b0;
   end

   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> q); // R7
   AST_FLAG_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set) |=> !q); // R7
   AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (q && !clr) |=> q); // R5
endmodule

// File: rtl/tagged_adc_fifo.sv
module tagged_adc_fifo
   import adcbuf_pkg::*;
#(
   parameter int  DEPTH     = 64,
   parameter bit  RANGE_CHK = 1'b1,
   localparam int CW        = $clog2(DEPTH + 1),
   localparam int STEPS     = 1 << TAG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [VAL_W-1:0]  wr_value,
   input  logic [TAG_W-1:0]  wr_step,
   input  logic              rd_en,
   output logic [WORD_W-1:0] rd_data,
   output logic [CW-1:0]     level,
   input  logic [VAL_W-1:0]  chk_max,
   input  logic [STEPS-1:0]  chk_mask,
   input  logic              ovr_clr,
   input  logic              oor_clr,
   output logic              ovr_flag,
   output logic              oor_flag
);
   word_t wword;
   logic  evict, range_hit;
   logic [1:0] f_set, f_clr, f_q;

   assign wword.tag = wr_step;
   assign wword.val = wr_value;

   adcbuf_store #(.DEPTH(DEPTH), .WIDTH(WORD_W)) store_i (
      .clk(clk), .rst_n(rst_n), .push(wr_en), .pop_req(rd_en),
      .din(wword), .dout(rd_data), .count(level), .evict(evict));

   adcbuf_range #(.VAL_W(VAL_W), .TAG_W(TAG_W), .ENABLE(RANGE_CHK)) range_i (
      .valid(wr_en), .value(wr_value), .step(wr_step),
      .limit(chk_max), .mask(chk_mask), .hit(range_hit));

   assign f_set = {range_hit, evict};
   assign f_clr = {oor_clr, ovr_clr};

   generate
      for (genvar k = 0; k < 2; k++) begin : g_flag
         adcbuf_flag flag_i (.clk(clk), .rst_n(rst_n),
            .set(f_set[k]), .clr(f_clr[k]), .q(f_q[k]));
      end
   endgenerate

   assign ovr_flag = f_q[0];
   assign oor_flag = f_q[1];

   AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (level == '0) |-> rd_data == '0); // R8
   AST_NO_OVR_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && rd_en && !ovr_flag && !ovr_clr) |=> !ovr_flag); // R5
   AST_OVR_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !rd_en && level == CW'(DEPTH)) |=> ovr_flag); // R5
endmodule

// File: tb/tagged_adc_fifo_tb_top.sv
`timescale 1ns/1ps
module tagged_adc_fifo_tb_top;
   logic clk = 0, rst_n = 0;
   logic wr_en = 0, rd_en = 0, ovr_clr = 0, oor_clr = 0;
   logic [11:0] wr_value = 0, chk_max = 0;
   logic [3:0]  wr_step = 0;
   logic [15:0] chk_mask = 0, rd_data;
   logic [6:0]  level;
   logic ovr_flag, oor_flag;

   int errors = 0, checks = 0;
   bit done = 0;
   logic [15:0] mq[$];
   bit m_ovr = 0, m_oor = 0;

   always #4 clk = ~clk;

   tagged_adc_fifo dut_i (.*);

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(bit w, int v, int s, bit r, bit co = 0, bit cr = 0);
      bit full_b, pop, ovr_ev, oor_ev;
      @(negedge clk);
      wr_en = w; wr_value = 12'(v); wr_step = 4'(s); rd_en = r;
      ovr_clr = co; oor_clr = cr;
      #1;
      if (r) begin
         if (mq.size() == 0) chk("R8 empty read", int'(rd_data), 0);
         else if (w) chk("R9 rdwr data", int'(rd_data), int'(mq[0]));
         else chk("R2 order", int'(rd_data), int'(mq[0]));
      end
      full_b = (mq.size() == 64);
      pop    = r && mq.size() != 0;
      ovr_ev = w && full_b && !pop;
      oor_ev = w && chk_mask[s[3:0]] && (v > int'(chk_max));
      @(posedge clk);
      #1;
      if (pop || ovr_ev) void'(mq.pop_front());
      if (w) mq.push_back({4'(s), 12'(v)});
      m_ovr = ovr_ev | (m_ovr & ~co);
      m_oor = oor_ev | (m_oor & ~cr);
      chk("R3 level", int'(level), mq.size());
      chk("R5 ovr_flag", int'(ovr_flag), int'(m_ovr));
      chk("R6 oor_flag", int'(oor_flag), int'(m_oor));
      wr_en = 0; rd_en = 0; ovr_clr = 0; oor_clr = 0;
   endtask

   initial begin
      #2000000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      // R10 reset state
      chk("R10 level", int'(level), 0);
      chk("R10 flags", int'({ovr_flag, oor_flag}), 0);
      chk("R10 rd_data", int'(rd_data), 0);
      // R8 empty reads, then R1 word format
      cyc(0, 0, 0, 1);
      cyc(0, 0, 0, 1);
      cyc(1, 12'hABC, 9, 0);
      @(negedge clk);
      chk("R1 tag", int'(rd_data[15:12]), 9);
      chk("R1 value", int'(rd_data[11:0]), 12'hABC);
      cyc(1, 12'h123, 3, 1);          // R9 at level 1
      cyc(0, 0, 0, 1);
      cyc(1, 12'h055, 2, 1);          // R8 rd+wr on empty
      cyc(0, 0, 0, 1);
      // fill sweep to full: R3
      for (int i = 0; i < 64; i++) cyc(1, (i * 61 + 7) & 12'hFFF, i % 16, 0);
      chk("R3 full level", int'(level), 64);
      cyc(1, 12'h777, 5, 1);          // R5/R9 swap on full: no overrun
      cyc(1, 12'h111, 1, 1);
      // R4 overwrite on full
      for (int i = 0; i < 10; i++) cyc(1, 12'hF00 + i, 15 - i, 0);
      chk("R4 level", int'(level), 64);
      cyc(0, 0, 0, 0, 1);             // R7 clear overrun
      cyc(1, 12'h222, 4, 0, 1);       // R7 set wins over clear
      // drain half, mid-level rd/wr mix
      for (int i = 0; i < 30; i++) cyc(0, 0, 0, 1);
      for (int i = 0; i < 20; i++) cyc(1, i * 3, i % 16, 1);
      for (int i = 0; i < 40; i++) cyc(0, 0, 0, 1);
      cyc(0, 0, 0, 1, 1);
      // R6 range sweep
      chk_max = 12'h800;
      chk_mask = 16'h5555;
      for (int s = 0; s < 16; s++) begin
         for (int d = -1; d <= 1; d++) begin
            cyc(1, 12'h800 + d, s, 1);
            cyc(0, 0, 0, 0, 0, 1);
         end
      end
      chk_mask = 16'hFFFF; chk_max = 12'hFFF;
      cyc(1, 12'hFFF, 7, 1);          // equal to max: no flag
      chk_max = 12'h000;
      cyc(1, 12'h001, 6, 1);
      cyc(1, 12'h002, 6, 1, 0, 1);    // R7 set wins for oor
      cyc(0, 0, 0, 1, 0, 1);
      for (int i = 0; i < 8; i++) cyc(0, 0, 0, 1);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule